// File: doc/BRIEF.md
# Ping-Pong Process Image with Boundary Commit

This block keeps two equally sized images of cyclic process data so that a network-side producer and an application-side consumer never touch the same words at the same time. The producer always writes into the staging image. The consumer always reads from the published image. When the cycle boundary input is sampled high, the two images trade roles in one clock edge. Each such swap also advances a version number and captures the value of a free-running time input. A reader can therefore use a version-check protocol to detect a swap that happened while it was reading.

Writes are accepted while the write-window input is high. A write that arrives while the window is closed, or in the same clock as the boundary, is late. It is held back and placed into the staging image of the following cycle, so the image about to be published does not change. Late writes are counted. A separate counter records each full cycle period that elapses without a boundary. After each swap the new staging image is made equal to the image just published. Only regions marked in a per-region dirty mask are copied. Words left untouched in a cycle therefore keep their last published value.

Top module: `ppio_commit_image`

## Requirements
- R1: A write with `net_wr_en` and `wr_window` high and `cyc_boundary` low lands only in the staging image. `app_rd_data` (a combinational read of the published word at `app_rd_addr`) does not show it before the next boundary.
- R2: The published image changes only at a rising edge where `cyc_boundary` is high. Between boundaries, `app_rd_data` for a fixed address is constant.
- R3: At a boundary edge the roles swap, and from that edge the read port returns every value written during the cycle. The new staging image starts equal to the newly published image (dirty regions of `RW` words are copied), so a word not written in the next cycle is still published unchanged after the following boundary.
- R4: Every boundary edge adds one to `commit_version`, modulo 2^VER_W, and loads `tstamp_in` into `commit_tstamp`. This holds even when no write occurred in the cycle. Neither output changes at any other edge.
- R5: A write with `wr_window` low (and no boundary) is deferred. It is not published by the next boundary, but is published by the boundary after that. An in-window write to the same address during that later cycle overrides it.
- R6: A write in the same clock as a boundary belongs to the following cycle. It is published by the next boundary after that one and takes priority over a deferred write to the same word.
- R7: `late_wr_count` grows by one for each write with `wr_window` low or `cyc_boundary` high, wrapping modulo 2^CNT_W. In-window writes leave it unchanged.
- R8: `missed_commit_count` grows by one on every `PERIOD_MAX`-th consecutive clock without a boundary. A boundary restarts that run and never changes the count itself.
- R9: A low `rst_n` at once clears both images, the version, the timestamp and both counters. Release takes effect after two rising edges with `rst_n` high.
- R10: A reader that samples `commit_version`, then the data, then the version again sees two different versions exactly when a boundary fell between the samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_boundary | input | 1 | Cycle boundary strobe; swap at this edge |
| wr_window | input | 1 | High while network writes are on time |
| tstamp_in | input | TS_W | Time base captured at each swap |
| net_wr_en | input | 1 | Network write strobe |
| net_wr_addr | input | AW | Network write word address |
| net_wr_data | input | DW | Network write data |
| app_rd_addr | input | AW | Application read address |
| app_rd_data | output | DW | Published word at `app_rd_addr` |
| commit_version | output | VER_W | Swap count, wrapping |
| commit_tstamp | output | TS_W | Time base at the last swap |
| late_wr_count | output | CNT_W | Late writes, wrapping |
| missed_commit_count | output | CNT_W | Cycle periods without a boundary, wrapping |

## Verification
A network write can land in the same clock as the cycle boundary. In that cycle, the per-word choice among the boundary write, a pending deferred write and the dirty-region copy all resolve in one edge. The bench provokes this directly, with a boundary-clock write to a word that also holds a deferred value. It also provokes it heavily in a long random phase with frequent boundaries and a closed window. Each case is judged by comparing the published word, the version and the late count against a behavioural model on every clock, and by explicit checks one and two boundaries later.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e flip_bank(bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/ppio_bank.sv
module ppio_bank #(
  parameter int DEPTH = 16,
  parameter int DW    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0]          ld_en,
  input  logic [DEPTH-1:0][DW-1:0]  ld_data,
  output logic [DEPTH-1:0][DW-1:0]  q
);
  // one storage word per entry, each with its own load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ld_en[i]) q[i] <= ld_data[i];
      end
    end
  end
endmodule

// File: rtl/ppio_defer.sv
module ppio_defer #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_en,
  input  logic [AW-1:0]             cap_addr,
  input  logic [DW-1:0]             cap_data,
  input  logic                      drain,
  output logic [DEPTH-1:0]          pend_vld,
  output logic [DEPTH-1:0][DW-1:0]  pend_data
);
  logic [DEPTH-1:0] vld_nxt;

  always_comb begin
    vld_nxt = pend_vld;
    if (drain) vld_nxt = '0;
    else if (cap_en) vld_nxt[cap_addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= '0;
      pend_data <= '0;
    end else begin
      pend_vld <= vld_nxt;
      if (cap_en) pend_data[cap_addr] <= cap_data;
    end
  end
endmodule

// File: rtl/ppio_swap_ctrl.sv
module ppio_swap_ctrl
  import ppio_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RW    = 4,
  parameter int AW    = 4,
  parameter int VER_W = 8,
  parameter int TS_W  = 32,
  localparam int NREG = DEPTH / RW,
  localparam int RSH  = $clog2(RW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             inwin_wr,
  input  logic             bnd_wr,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DEPTH-1:0] pend_vld,
  input  logic [TS_W-1:0]  tstamp_in,
  output bank_e            pub_bank,
  output logic [NREG-1:0]  dirty,
  output logic [VER_W-1:0] version,
  output logic [TS_W-1:0]  tstamp
);
  logic [NREG-1:0]  dirty_nxt;
  logic [VER_W-1:0] version_nxt;

  always_comb begin
    dirty_nxt = dirty;
    if (boundary) begin
      // new cycle: regions touched by carried-over writes start dirty
      dirty_nxt = '0;
      for (int r = 0; r < NREG; r++) begin
        for (int w = 0; w < RW; w++) begin
          if (pend_vld[r*RW + w]) dirty_nxt[r] = 1'b1;
        end
      end
      if (bnd_wr) dirty_nxt[wr_addr[AW-1:RSH]] = 1'b1;
    end else if (inwin_wr) begin
      dirty_nxt[wr_addr[AW-1:RSH]] = 1'b1;
    end
    version_nxt = version + VER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pub_bank <= BANK_A;
      dirty    <= '0;
      version  <= '0;
      tstamp   <= '0;
    end else begin
      dirty <= dirty_nxt;
      if (boundary) begin
        pub_bank <= flip_bank(pub_bank);
        version  <= version_nxt;
        tstamp   <= tstamp_in;
      end
    end
  end
endmodule

// File: rtl/ppio_health.sv
module ppio_health #(
  parameter int CNT_W      = 8,
  parameter int PERIOD_MAX = 64,
  localparam int CYC_W     = (PERIOD_MAX > 1) ? $clog2(PERIOD_MAX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             late_ev,
  output logic [CNT_W-1:0] late_cnt,
  output logic [CNT_W-1:0] missed_cnt
);
  logic [CYC_W-1:0] run_q;
  logic [CYC_W-1:0] run_d;
  logic             miss_ev;
  logic [CNT_W-1:0] late_d;
  logic [CNT_W-1:0] missed_d;

  always_comb begin
    miss_ev  = !boundary && (run_q == CYC_W'(PERIOD_MAX - 1));
    run_d    = (boundary || miss_ev) ? '0 : run_q + CYC_W'(1);
    late_d   = late_cnt + CNT_W'(1);
    missed_d = missed_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      late_cnt   <= '0;
      missed_cnt <= '0;
    end else begin
      run_q <= run_d;
      if (late_ev) late_cnt   <= late_d;
      if (miss_ev) missed_cnt <= missed_d;
    end
  end
endmodule

// File: rtl/ppio_commit_image.sv
module ppio_commit_image
  import ppio_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DW         = 16,
  parameter int RW         = 4,
  parameter int VER_W      = 8,
  parameter int TS_W       = 32,
  parameter int CNT_W      = 8,
  parameter int PERIOD_MAX = 64,
  localparam int AW        = $clog2(DEPTH),
  localparam int NREG      = DEPTH / RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_boundary,
  input  logic             wr_window,
  input  logic [TS_W-1:0]  tstamp_in,
  input  logic             net_wr_en,
  input  logic [AW-1:0]    net_wr_addr,
  input  logic [DW-1:0]    net_wr_data,
  input  logic [AW-1:0]    app_rd_addr,
  output logic [DW-1:0]    app_rd_data,
  output logic [VER_W-1:0] commit_version,
  output logic [TS_W-1:0]  commit_tstamp,
  output logic [CNT_W-1:0] late_wr_count,
  output logic [CNT_W-1:0] missed_commit_count
);
  // reset: asserted at once, released after two clean edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // write classification
  logic inwin_wr;
  logic bnd_wr;
  logic defer_wr;
  logic late_ev;

  assign inwin_wr = net_wr_en && wr_window && !cyc_boundary;
  assign bnd_wr   = net_wr_en && cyc_boundary;
  assign defer_wr = net_wr_en && !wr_window && !cyc_boundary;
  assign late_ev  = bnd_wr || defer_wr;

  bank_e                     pub_bank;
  logic [NREG-1:0]           dirty;
  logic [DEPTH-1:0]          pend_vld;
  logic [DEPTH-1:0][DW-1:0]  pend_data;
  logic [DEPTH-1:0][DW-1:0]  bank_q [2];

  ppio_swap_ctrl #(
    .DEPTH(DEPTH), .RW(RW), .AW(AW), .VER_W(VER_W), .TS_W(TS_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .boundary  (cyc_boundary),
    .inwin_wr  (inwin_wr),
    .bnd_wr    (bnd_wr),
    .wr_addr   (net_wr_addr),
    .pend_vld  (pend_vld),
    .tstamp_in (tstamp_in),
    .pub_bank  (pub_bank),
    .dirty     (dirty),
    .version   (commit_version),
    .tstamp    (commit_tstamp)
  );

  ppio_defer #(
    .DEPTH(DEPTH), .DW(DW), .AW(AW)
  ) u_defer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_en    (defer_wr),
    .cap_addr  (net_wr_addr),
    .cap_data  (net_wr_data),
    .drain     (cyc_boundary),
    .pend_vld  (pend_vld),
    .pend_data (pend_data)
  );

  ppio_health #(
    .CNT_W(CNT_W), .PERIOD_MAX(PERIOD_MAX)
  ) u_health (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .boundary   (cyc_boundary),
    .late_ev    (late_ev),
    .late_cnt   (late_wr_count),
    .missed_cnt (missed_commit_count)
  );

  // two banks; per-word load selection depends on each bank's current role
  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam bank_e SELF = (b == 0) ? BANK_A : BANK_B;
    logic                     is_stage;
    logic [DEPTH-1:0]         ld_en;
    logic [DEPTH-1:0][DW-1:0] ld_data;

    assign is_stage = (pub_bank != SELF);

    always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cyc_boundary) begin
          // bank leaving publication becomes the new staging image
          ld_en[i] = !is_stage &&
                     ((bnd_wr && (net_wr_addr == AW'(i))) || pend_vld[i] || dirty[i / RW]);
          if (bnd_wr && (net_wr_addr == AW'(i)))
            ld_data[i] = net_wr_data;
          else if (pend_vld[i])
            ld_data[i] = pend_data[i];
          else
            ld_data[i] = bank_q[1-b][i];
        end else begin
          ld_en[i]   = is_stage && inwin_wr && (net_wr_addr == AW'(i));
          ld_data[i] = net_wr_data;
        end
      end
    end

    ppio_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .ld_en   (ld_en),
      .ld_data (ld_data),
      .q       (bank_q[b])
    );
  end

  assign app_rd_data = (pub_bank == BANK_B) ? bank_q[1][app_rd_addr] : bank_q[0][app_rd_addr];
endmodule

// File: rtl/ppio_commit_checks.sv
module ppio_commit_checks #(
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int VER_W = 8,
  parameter int TS_W  = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_boundary,
  input logic             wr_window,
  input logic             net_wr_en,
  input logic [TS_W-1:0]  tstamp_in,
  input logic [AW-1:0]    app_rd_addr,
  input logic [DW-1:0]    app_rd_data,
  input logic [VER_W-1:0] commit_version,
  input logic [TS_W-1:0]  commit_tstamp,
  input logic [CNT_W-1:0] late_wr_count,
  input logic [CNT_W-1:0] missed_commit_count
);
  logic late_in;
  assign late_in = net_wr_en && (!wr_window || cyc_boundary);

  assert_published_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_boundary |=> ($stable(app_rd_addr) -> $stable(app_rd_data)));

  assert_version_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_boundary |=> commit_version == $past(commit_version) + VER_W'(1));

  assert_version_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_boundary |=> $stable(commit_version) && $stable(commit_tstamp));

  assert_tstamp_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_boundary |=> commit_tstamp == $past(tstamp_in));

  assert_late_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    late_in |=> late_wr_count == $past(late_wr_count) + CNT_W'(1));

  assert_late_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !late_in |=> $stable(late_wr_count));

  assert_missed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_boundary |=> $stable(missed_commit_count));
endmodule

bind ppio_commit_image ppio_commit_checks #(
  .AW(AW), .DW(DW), .VER_W(VER_W), .TS_W(TS_W), .CNT_W(CNT_W)
) u_checks (
  .clk                 (clk),
  .rst_n               (rst_sync_n),
  .cyc_boundary        (cyc_boundary),
  .wr_window           (wr_window),
  .net_wr_en           (net_wr_en),
  .tstamp_in           (tstamp_in),
  .app_rd_addr         (app_rd_addr),
  .app_rd_data         (app_rd_data),
  .commit_version      (commit_version),
  .commit_tstamp       (commit_tstamp),
  .late_wr_count       (late_wr_count),
  .missed_commit_count (missed_commit_count)
);

// File: tb/ppio_commit_image_test.sv
module ppio_commit_image_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int DW         = 16;
  localparam int RW         = 4;
  localparam int VER_W      = 8;
  localparam int TS_W       = 32;
  localparam int CNT_W      = 8;
  localparam int PERIOD_MAX = 64;
  localparam int AW         = 4;

  logic             clk;
  logic             rst_n;
  logic             cyc_boundary;
  logic             wr_window;
  logic [TS_W-1:0]  tstamp_in;
  logic             net_wr_en;
  logic [AW-1:0]    net_wr_addr;
  logic [DW-1:0]    net_wr_data;
  logic [AW-1:0]    app_rd_addr;
  logic [DW-1:0]    app_rd_data;
  logic [VER_W-1:0] commit_version;
  logic [TS_W-1:0]  commit_tstamp;
  logic [CNT_W-1:0] late_wr_count;
  logic [CNT_W-1:0] missed_commit_count;

  ppio_commit_image #(
    .DEPTH(DEPTH), .DW(DW), .RW(RW), .VER_W(VER_W), .TS_W(TS_W),
    .CNT_W(CNT_W), .PERIOD_MAX(PERIOD_MAX)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cyc_boundary(cyc_boundary), .wr_window(wr_window),
    .tstamp_in(tstamp_in), .net_wr_en(net_wr_en), .net_wr_addr(net_wr_addr),
    .net_wr_data(net_wr_data), .app_rd_addr(app_rd_addr), .app_rd_data(app_rd_data),
    .commit_version(commit_version), .commit_tstamp(commit_tstamp),
    .late_wr_count(late_wr_count), .missed_commit_count(missed_commit_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  task automatic check(string req, longint act, longint exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int pub_img   [DEPTH];
  int stage_img [DEPTH];
  bit held_v    [DEPTH];
  int held_d    [DEPTH];
  int m_ver, m_late, m_missed, m_run, rel_edges;
  longint m_ts;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        pub_img[i] = 0; stage_img[i] = 0; held_v[i] = 0; held_d[i] = 0;
      end
      m_ver = 0; m_late = 0; m_missed = 0; m_run = 0; m_ts = 0; rel_edges = 0;
    end else if (rel_edges < 2) begin
      rel_edges++;
    end else if (cyc_boundary) begin
      for (int i = 0; i < DEPTH; i++) pub_img[i] = stage_img[i];
      for (int i = 0; i < DEPTH; i++) begin
        if (held_v[i]) stage_img[i] = held_d[i];
        held_v[i] = 0;
      end
      if (net_wr_en) begin
        stage_img[net_wr_addr] = net_wr_data;
        m_late = (m_late + 1) % 256;
      end
      m_ver = (m_ver + 1) % 256;
      m_ts  = tstamp_in;
      m_run = 0;
    end else begin
      if (net_wr_en) begin
        if (wr_window) stage_img[net_wr_addr] = net_wr_data;
        else begin
          held_v[net_wr_addr] = 1; held_d[net_wr_addr] = net_wr_data;
          m_late = (m_late + 1) % 256;
        end
      end
      if (m_run == PERIOD_MAX - 1) begin
        m_run = 0; m_missed = (m_missed + 1) % 256;
      end else m_run++;
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    check("R2", app_rd_data, pub_img[app_rd_addr], "published word vs model");
    check("R4", commit_version, m_ver, "version vs model");
    check("R4", commit_tstamp, m_ts, "timestamp vs model");
    check("R7", late_wr_count, m_late, "late count vs model");
    check("R8", missed_commit_count, m_missed, "missed count vs model");
  end

  // ---------------- stimulus helpers ----------------
  initial begin
    tstamp_in = '0;
    forever begin
      @(negedge clk);
      tstamp_in = tstamp_in + 32'd3;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(int a, int d, bit win);
    net_wr_en = 1; net_wr_addr = AW'(a); net_wr_data = DW'(d); wr_window = win;
    @(negedge clk);
    net_wr_en = 0; wr_window = 1;
  endtask

  task automatic swap();
    cyc_boundary = 1;
    @(negedge clk);
    cyc_boundary = 0;
  endtask

  task automatic peek(string req, int a, int exp, string what);
    app_rd_addr = AW'(a);
    #1;
    check(req, app_rd_data, exp, what);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    report();
  end

  initial begin
    int v0, v1, v2, m0, d0;
    rst_n = 0; cyc_boundary = 0; wr_window = 1; net_wr_en = 0;
    net_wr_addr = '0; net_wr_data = '0; app_rd_addr = '0;
    tick(3);
    rst_n = 1;
    tick(4);

    // R9: reset state
    peek("R9", 3, 0, "word after reset");
    check("R9", commit_version, 0, "version after reset");
    check("R9", late_wr_count, 0, "late count after reset");
    check("R9", missed_commit_count, 0, "missed count after reset");

    // R1 / R3: staged writes, then publish
    for (int i = 0; i < 4; i++) put(i, 16'h1100 + i, 1);
    peek("R1", 1, 0, "staged write not yet visible");
    swap();
    peek("R3", 1, 16'h1101, "published after boundary");
    check("R4", commit_version, 1, "version after first boundary");

    // R3: untouched word survives the next cycle
    put(5, 16'h5555, 1);
    swap();
    peek("R3", 0, 16'h1100, "unwritten word keeps value");
    peek("R3", 5, 16'h5555, "written word published");

    // R5: write with window closed is deferred one cycle
    put(2, 16'hDEAD, 0);
    check("R7", late_wr_count, 1, "late count after closed-window write");
    swap();
    peek("R5", 2, 16'h1102, "deferred write not in next commit");
    swap();
    peek("R5", 2, 16'hDEAD, "deferred write in following commit");

    // R5: deferred value overridden by an in-window write of that cycle
    put(3, 16'hAAAA, 0);
    swap();
    put(3, 16'hBBBB, 1);
    swap();
    peek("R5", 3, 16'hBBBB, "in-window write overrides deferred");

    // R6: boundary-clock write, priority over deferred value
    put(7, 16'h0707, 0);
    cyc_boundary = 1; net_wr_en = 1; net_wr_addr = 4'd7; net_wr_data = 16'h7777;
    @(negedge clk);
    cyc_boundary = 0; net_wr_en = 0;
    peek("R6", 7, 0, "boundary-clock write not in this commit");
    check("R7", late_wr_count, 4, "late count after boundary-clock write");
    swap();
    peek("R6", 7, 16'h7777, "boundary-clock write wins next commit");

    // R4: empty cycles still advance the version
    v0 = commit_version;
    swap(); swap(); swap();
    check("R4", commit_version, (v0 + 3) % 256, "version after empty boundaries");

    // R8: missed periods
    m0 = missed_commit_count;
    swap();
    tick(2 * PERIOD_MAX);
    check("R8", missed_commit_count, m0 + 2, "missed after two silent periods");
    swap();
    tick(PERIOD_MAX - 1);
    check("R8", missed_commit_count, m0 + 2, "boundary restarts period");
    tick(1);
    check("R8", missed_commit_count, m0 + 3, "missed at period end");

    // R10: version-data-version read
    put(9, 16'h9999, 1);
    v1 = commit_version;
    peek("R10", 9, 0, "old data before swap");
    swap();
    v2 = commit_version;
    check("R10", (v1 != v2) ? 1 : 0, 1, "swap during read detected");
    v1 = commit_version;
    app_rd_addr = 4'd9; #1; d0 = app_rd_data;
    tick(2);
    v2 = commit_version;
    check("R10", (v1 == v2 && app_rd_data == d0) ? 1 : 0, 1, "quiet read consistent");

    // mixed random traffic compared against the model each clock
    for (int k = 0; k < 2000; k++) begin
      cyc_boundary = ($urandom % 10) == 0;
      wr_window    = ($urandom % 4) != 0;
      net_wr_en    = ($urandom % 2) == 1;
      net_wr_addr  = AW'($urandom);
      net_wr_data  = DW'($urandom);
      app_rd_addr  = AW'($urandom);
      @(negedge clk);
    end
    cyc_boundary = 0; net_wr_en = 0; wr_window = 1;
    tick(2);

    // R9: asynchronous assertion of reset
    rst_n = 0;
    #1;
    check("R9", commit_version, 0, "version cleared without a clock");
    check("R9", late_wr_count, 0, "late count cleared without a clock");
    tick(2);
    rst_n = 1;
    tick(4);
    peek("R9", 9, 0, "word cleared by reset");

    report();
  end
endmodule